// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block sits between an instruction fetch stage and a decoder. Each 18-bit instruction word holds four zero-operand opcodes. The block stores one word and a slot counter. It presents the opcodes one at a time on a valid/accept output, working from the most significant slot down to the least significant one.

The first three slots are 5 bits wide, so each of them can carry any of the 32 opcodes. The last slot has only 3 bits. The block widens it to a 5-bit opcode by appending two zero bits on the right, so only opcodes that are multiples of 4 can appear there.

A word is retired in three cases: its last slot is accepted, an accepted opcode belongs to a configurable set of word-ending opcodes, or the flush input is raised. When a word is retired, the block asks the fetch side for the next word through a valid/ready handshake. A word that arrives in the same cycle as the retirement is loaded without a bubble.

Top module: `isq_slot_seq`

## Requirements
- R1: While reset is applied and right after it, `op_valid_o` is 0 and `word_ready_o` is 1.
- R2: Slots are issued in the order 0, 1, 2, 3, with `slot_o` giving the index. Slot 0 is bits 17:13, slot 1 is bits 12:8 and slot 2 is bits 7:3, each issued as a full 5-bit opcode.
- R3: Slot 3 is bits 2:0, issued as `{bits[2:0], 2'b00}`, so `op_o[1:0]` is 0 whenever `slot_o` is 3.
- R4: While `op_valid_o` is 1 and `op_accept_i` is 0 (and no flush is raised), `op_o`, `slot_o` and `op_valid_o` hold their values into the next cycle.
- R5: In the cycle slot 3 is accepted, `word_ready_o` is 1. A word with `word_valid_i` in that cycle is presented at slot 0 in the next cycle.
- R6: Accepting an opcode whose value is in the word-ending set (default: opcodes 0 to 3) retires the word at once. `word_ready_o` is 1 in that cycle, and the rest of the word's slots are never issued.
- R7: While `flush_i` is 1, `op_valid_o` is 0 and `word_ready_o` is 1. The rest of the current word is dropped, and the next word loaded starts at slot 0.
- R8: While a word is held and not being retired, `word_ready_o` is 0, and `word_i`/`word_valid_i` have no effect on the issued opcodes.
- R9: A word that arrives valid in the same cycle as a flush is loaded, and it is presented at slot 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 18 | Instruction word from fetch |
| word_valid_i | input | 1 | Fetch word valid |
| word_ready_o | output | 1 | Sequencer can take a word this cycle |
| flush_i | input | 1 | Drop the rest of the current word |
| op_o | output | 5 | Current opcode |
| slot_o | output | 2 | Slot index of `op_o` |
| op_valid_o | output | 1 | `op_o` is valid |
| op_accept_i | input | 1 | Downstream takes `op_o` |

## Verification
Retiring a word and loading the next one can fall in the same cycle. This happens when the last slot is accepted, when an accepted opcode ends the word, or when a flush is raised, each while the fetch side already offers a valid word. The bench provokes all three cases directly, and then drives random flush, accept and word-valid patterns. A behavioural reference model decides on every clock whether the arriving word is taken and whether slot 0 of that word follows. The outputs are compared against that model on every clock.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int unsigned WORD_W_DEF = 18;
  localparam int unsigned OP_W_DEF   = 5;
  localparam int unsigned SLOTS_DEF  = 4;

  function automatic int unsigned last_slot_w(int unsigned word_w, int unsigned op_w,
                                              int unsigned slots);
    return word_w - op_w * (slots - 1);
  endfunction
endpackage

// File: rtl/isq_slot_mux.sv
module isq_slot_mux
  import isq_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned OP_W   = OP_W_DEF,
  parameter int unsigned SLOTS  = SLOTS_DEF,
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned LAST_W = last_slot_w(WORD_W, OP_W, SLOTS)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  slot_i,
  output logic [OP_W-1:0]   op_o
);
  logic [OP_W-1:0] cand [SLOTS];

  for (genvar s = 0; s < SLOTS - 1; s++) begin : g_full
    assign cand[s] = word_i[WORD_W-1-s*OP_W -: OP_W];
  end

  // short last slot is left-aligned, low bits padded with zero
  if (LAST_W < OP_W) begin : g_short
    assign cand[SLOTS-1] = {word_i[LAST_W-1:0], {(OP_W-LAST_W){1'b0}}};
  end else begin : g_exact
    assign cand[SLOTS-1] = word_i[OP_W-1:0];
  end

  assign op_o = cand[slot_i];
endmodule

// File: rtl/isq_end_detect.sv
module isq_end_detect #(
  parameter int unsigned OP_W = 5,
  parameter logic [(1<<OP_W)-1:0] END_MASK = 32'h0000_000F
) (
  input  logic [OP_W-1:0] op_i,
  output logic            end_o
);
  assign end_o = END_MASK[op_i];
endmodule

// File: rtl/isq_word_ctrl.sv
module isq_word_ctrl
  import isq_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned SLOTS  = SLOTS_DEF,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic              flush_i,
  input  logic              accept_i,
  input  logic              end_hit_i,
  output logic [WORD_W-1:0] word_q,
  output logic [IDX_W-1:0]  slot_q,
  output logic              op_valid_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(SLOTS - 1);

  logic have_q;
  logic fire, retire, load;

  assign op_valid_o   = have_q & ~flush_i;
  assign fire         = op_valid_o & accept_i;
  assign retire       = flush_i | (fire & ((slot_q == LastIdx) | end_hit_i));
  assign word_ready_o = ~have_q | retire;
  assign load         = word_valid_i & word_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      slot_q <= '0;
      word_q <= '0;
    end else if (load) begin
      have_q <= 1'b1;
      slot_q <= '0;
      word_q <= word_i;
    end else if (retire) begin
      have_q <= 1'b0;
      slot_q <= '0;
    end else if (fire) begin
      slot_q <= slot_q + IDX_W'(1);
    end
  end

  AST_LOAD_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && word_ready_o |=> have_q && slot_q == '0); // R5
  AST_FLUSH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !word_valid_i |=> !have_q); // R7
  AST_SLOT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && accept_i && !word_ready_o |=> slot_q == $past(slot_q) + IDX_W'(1)); // R2
  AST_HOLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_q && !word_ready_o |=> $stable(word_q)); // R8
endmodule

// File: rtl/isq_slot_seq.sv
module isq_slot_seq
  import isq_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned OP_W   = OP_W_DEF,
  parameter int unsigned SLOTS  = SLOTS_DEF,
  parameter logic [(1<<OP_W)-1:0] END_MASK = 32'h0000_000F,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic              flush_i,
  output logic [OP_W-1:0]   op_o,
  output logic [IDX_W-1:0]  slot_o,
  output logic              op_valid_o,
  input  logic              op_accept_i
);
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  slot_q;
  logic              end_hit;

  isq_word_ctrl #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_ctrl (
    .clk_i, .rst_ni, .word_i, .word_valid_i, .word_ready_o, .flush_i,
    .accept_i (op_accept_i),
    .end_hit_i(end_hit),
    .word_q, .slot_q, .op_valid_o
  );

  isq_slot_mux #(.WORD_W(WORD_W), .OP_W(OP_W), .SLOTS(SLOTS)) u_mux (
    .word_i(word_q), .slot_i(slot_q), .op_o
  );

  isq_end_detect #(.OP_W(OP_W), .END_MASK(END_MASK)) u_end (
    .op_i(op_o), .end_o(end_hit)
  );

  assign slot_o = slot_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && !op_accept_i ##1 !flush_i |-> $stable(op_o) && $stable(slot_o) && op_valid_o); // R4
  AST_LAST_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && slot_o == IDX_W'(SLOTS - 1) |-> op_o[1:0] == 2'b00); // R3
  AST_RETIRE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_accept_i && (slot_o == IDX_W'(SLOTS - 1) || END_MASK[op_o]) |-> word_ready_o); // R6
endmodule

// File: tb/isq_slot_seq_tb.sv
module isq_slot_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic        flush_i = 1'b0;
  logic [4:0]  op_o;
  logic [1:0]  slot_o;
  logic        op_valid_o;
  logic        op_accept_i = 1'b0;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  bit        m_have = 0;
  int        m_slot = 0;
  bit [17:0] m_word = '0;

  always #5 clk_i = ~clk_i;

  isq_slot_seq u_dut (.*);

  function automatic int ref_op(bit [17:0] w, int s);
    if (s == 3) return int'(w[2:0]) * 4;
    return int'((w >> (13 - 5 * s)) & 18'h1f);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive one cycle, compare against the model, then advance the model at the edge
  task automatic step(bit [17:0] w, bit wv, bit acc, bit fl, string tag);
    bit e_valid, e_ready, e_retire;
    int e_op;
    @(negedge clk_i);
    word_i = w; word_valid_i = wv; op_accept_i = acc; flush_i = fl;
    #1;
    e_valid  = m_have && !fl;
    e_op     = m_have ? ref_op(m_word, m_slot) : 0;
    e_retire = fl || (e_valid && acc && (m_slot == 3 || e_op < 4));
    e_ready  = !m_have || e_retire;
    chk(op_valid_o == e_valid, tag, "op_valid", int'(op_valid_o), int'(e_valid));
    chk(word_ready_o == e_ready, tag, "word_ready", int'(word_ready_o), int'(e_ready));
    if (e_valid) begin
      chk(int'(op_o) == e_op, tag, "op", int'(op_o), e_op);
      chk(int'(slot_o) == m_slot, tag, "slot", int'(slot_o), m_slot);
    end
    @(posedge clk_i);
    if (wv && e_ready) begin
      m_have = 1; m_word = w; m_slot = 0;
    end else if (e_retire) begin
      m_have = 0; m_slot = 0;
    end else if (e_valid && acc) begin
      m_slot++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(op_valid_o == 1'b0, "R1", "op_valid in reset", int'(op_valid_o), 0);
    chk(word_ready_o == 1'b1, "R1", "word_ready in reset", int'(word_ready_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step('0, 0, 0, 0, "R1");

    // R2 R3: full word, slot3 = 3'b101 -> 20
    step(18'b10101_01010_11100_101, 1, 1, 0, "R2");
    for (int i = 0; i < 4; i++) step('0, 0, 1, 0, "R3");
    // R4: stalls on each slot
    step(18'b11111_00100_10000_111, 1, 0, 0, "R4");
    for (int i = 0; i < 8; i++) step('0, 0, i[0], 0, "R4");
    // R5: back-to-back words, next offered while last slot retires
    for (int i = 0; i < 12; i++) step(18'h2_4924 + 18'(i * 9), 1, 1, 0, "R5");
    step('0, 0, 1, 0, "R5");
    for (int i = 0; i < 4; i++) step('0, 0, 1, 0, "R5");
    // R6: slot1 = 2 ends the word early, next word waiting
    step(18'b01000_00010_11111_111, 1, 1, 0, "R6");
    step('0, 0, 1, 0, "R6");
    step(18'b00111_01000_00100_011, 1, 1, 0, "R6");
    for (int i = 0; i < 5; i++) step('0, 0, 1, 0, "R6");
    // R7: flush mid-word with no word offered, then new word
    step(18'b10000_10001_10010_110, 1, 1, 0, "R7");
    step('0, 0, 1, 0, "R7");
    step('0, 0, 1, 1, "R7");
    step('0, 0, 1, 0, "R7");
    step(18'b11000_11001_11010_010, 1, 1, 0, "R7");
    step('0, 0, 0, 0, "R7");
    // R8: junk offered while holding, must be ignored
    step(18'h3_ffff, 1, 1, 0, "R8");
    step(18'h0_0000, 1, 0, 0, "R8");
    step(18'h1_5555, 1, 1, 0, "R8");
    step(18'h0_0001, 1, 0, 0, "R8");
    // R9: flush and new word in the same cycle
    step(18'b01111_01110_01101_100, 1, 1, 1, "R9");
    step('0, 0, 1, 0, "R9");
    step(18'b10100_10100_10100_001, 1, 0, 1, "R9");
    for (int i = 0; i < 5; i++) step('0, 0, 1, 0, "R9");
    // random mix
    for (int i = 0; i < 600; i++)
      step(18'($urandom), 1'($urandom), ($urandom % 4) != 0, ($urandom % 9) == 0, "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule